// File: doc/BRIEF.md
# Page Boundary Interrupt Status Unit

This unit watches completions of transfers that target a memory window and records, one bit per page, when a transfer reaches the final doubleword of a page. The window's lower half holds 64 pages by default. The page size is a parameter, 4 KB by default. The 64 status bits are split into two 32-bit words. Software clears a word's bits by writing ones to them. Each status bit has a mask bit. A single level-sensitive interrupt request is raised while any pending bit is unmasked. Logic outside the unit turns that request into a legacy interrupt or a message-signalled one.

Completions arrive as a valid/ready stream. The unit never applies back-pressure: `cpl_ready` is held high, so every beat with `cpl_valid` high is consumed in the cycle it is presented. The completion offset is given in doublewords relative to the window base, so the two byte-address bits are never carried. The register write port is plain control. `reg_sel` bit 1 picks mask (1) or status (0), and bit 0 picks the low word (pages 0–31) or the high word (pages 32–63).

Top module: `page_irq_status`

## Requirements
- R1: After reset all 64 status bits are 0, all 64 mask bits are 1, and `irq_o` is low.
- R2: A successful completion (`cpl_valid`=1, `cpl_ok`=1) in the lower half sets exactly one status bit at the next clock edge. The offset must have doubleword bits [9:0] all ones. The bit set is the one given by page bits [15:10].
- R3: A completion at any doubleword other than the last of its page (bits [9:0] not all ones) leaves the status unchanged.
- R4: A completion whose offset bit 16 is 1 (upper half of the window) leaves the status unchanged.
- R5: A completion with `cpl_ok`=0 (ended in error) leaves the status unchanged.
- R6: Status bit i belongs to page i. The low status word (`reg_sel`=0) holds pages 0–31 with bit 0 for page 0. The high word (`reg_sel`=1) holds pages 32–63 with bit 0 for page 32.
- R7: A status write clears every bit written as 1 at the next edge. Bits written as 0 keep their value.
- R8: If a page hit and a clear of the same bit happen in one cycle, the bit ends up set.
- R9: A write with `reg_sel`=2 or 3 loads the low or high 32 mask bits with `reg_wdata`. Other mask bits are not affected.
- R10: `irq_o` is high exactly while at least one status bit is 1 and its mask bit is 0.
- R11: `cpl_ready` is always 1. A cycle with `cpl_valid`=0 sets no status bit, whatever the other completion inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpl_valid | input | 1 | Completion beat present |
| cpl_ready | output | 1 | Always 1; the unit accepts every beat |
| cpl_ok | input | 1 | Completion finished without error |
| cpl_dw_ofs | input | 17 | Doubleword offset in the window: [16] half, [15:10] page, [9:0] doubleword |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | [1]=mask/status, [0]=high/low word |
| reg_wdata | input | 32 | Write data (ones clear status; loaded into mask) |
| status_o | output | 64 | Pending status bits, bit i = page i |
| mask_o | output | 64 | Mask bits, bit i = page i |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions assume that the completion and register inputs are known (no X) at every clock edge once reset is released. They also assume that `cpl_dw_ofs` and `cpl_ok` matter only in cycles where `cpl_valid` is high. Every `reg_sel` value is legal, so no assumption is made on it. The bench changes all inputs only on the falling clock edge and never leaves them undriven. It chooses offsets that land on the last doubleword often enough to exercise hits in both words. It also makes random writes that clear, and change masks, in the same cycles as hits.

// File: rtl/pbi_pkg.sv
package pbi_pkg;
  // Top bit of the register select: which register file a write lands in.
  typedef enum logic {
    ACC_STATUS = 1'b0,
    ACC_MASK   = 1'b1
  } pbi_acc_e;
endpackage

// File: rtl/pbi_page_decode.sv
module pbi_page_decode #(
  parameter int PAGE_LOG2 = 12,
  parameter int NUM_PAGES = 64,
  localparam int IDX_W = $clog2(NUM_PAGES),
  localparam int DWL   = PAGE_LOG2 - 2,
  localparam int OFS_W = DWL + IDX_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cpl_valid,
  input  logic                 cpl_ok,
  input  logic [OFS_W-1:0]     cpl_dw_ofs,
  output logic [NUM_PAGES-1:0] set_vec
);
  logic             in_low;
  logic             last_dw;
  logic [IDX_W-1:0] page_idx;
  logic             hit;

  assign in_low   = ~cpl_dw_ofs[OFS_W-1];
  assign last_dw  = &cpl_dw_ofs[DWL-1:0];
  assign page_idx = cpl_dw_ofs[DWL+IDX_W-1:DWL];
  assign hit      = cpl_valid & cpl_ok & in_low & last_dw;

  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
    assign set_vec[p] = hit && (page_idx == IDX_W'(p));
  end

  // A single completion marks at most one page.
  assert_one_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_vec));
endmodule

// File: rtl/pbi_reg_write.sv
module pbi_reg_write
  import pbi_pkg::*;
#(
  parameter int NUM_PAGES = 64,
  parameter int REG_W     = 32,
  localparam int NUM_REGS = NUM_PAGES / REG_W,
  localparam int RIDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int SEL_W    = RIDX_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [SEL_W-1:0]     sel,
  input  logic [REG_W-1:0]     wdata,
  output logic [NUM_PAGES-1:0] clr_vec,
  output logic [NUM_REGS-1:0]  mask_we
);
  pbi_acc_e          kind;
  logic [RIDX_W-1:0] ridx;

  assign kind = pbi_acc_e'(sel[SEL_W-1]);
  assign ridx = sel[RIDX_W-1:0];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic hit_r;
    assign hit_r = wr_en && (ridx == RIDX_W'(r));
    assign clr_vec[r*REG_W +: REG_W] = (hit_r && kind == ACC_STATUS) ? wdata : '0;
    assign mask_we[r] = hit_r && (kind == ACC_MASK);
  end

  assert_mask_one_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mask_we));
  // A mask write never clears status.
  assert_mask_no_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_we != '0) |-> (clr_vec == '0));
endmodule

// File: rtl/pbi_status_bank.sv
module pbi_status_bank #(
  parameter int NUM_PAGES = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PAGES-1:0] set_vec,
  input  logic [NUM_PAGES-1:0] clr_vec,
  output logic [NUM_PAGES-1:0] status
);
  always_ff @(posedge clk) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~clr_vec) | set_vec;
  end

  // A hit marks its bit even when cleared in the same cycle.
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((status & $past(set_vec)) == $past(set_vec)));
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec != '0) |=> ((status & $past(clr_vec) & ~$past(set_vec)) == '0));
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((status ^ $past(status)) & ~($past(set_vec) | $past(clr_vec))) == '0));
endmodule

// File: rtl/pbi_mask_bank.sv
module pbi_mask_bank #(
  parameter int NUM_PAGES = 64,
  parameter int REG_W     = 32,
  localparam int NUM_REGS = NUM_PAGES / REG_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_REGS-1:0]  mask_we,
  input  logic [REG_W-1:0]     wdata,
  output logic [NUM_PAGES-1:0] mask
);
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)          mask[r*REG_W +: REG_W] <= '1;
      else if (mask_we[r]) mask[r*REG_W +: REG_W] <= wdata;
    end

    assert_mask_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mask_we[r] |=> (mask[r*REG_W +: REG_W] == $past(wdata)));
    assert_mask_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_we[r] |=> $stable(mask[r*REG_W +: REG_W]));
  end
endmodule

// File: rtl/page_irq_status.sv
module page_irq_status #(
  parameter int PAGE_LOG2 = 12,
  parameter int NUM_PAGES = 64,
  parameter int REG_W     = 32,
  localparam int IDX_W    = $clog2(NUM_PAGES),
  localparam int OFS_W    = PAGE_LOG2 - 2 + IDX_W + 1,
  localparam int NUM_REGS = NUM_PAGES / REG_W,
  localparam int SEL_W    = ((NUM_REGS > 1) ? $clog2(NUM_REGS) : 1) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cpl_valid,
  output logic                 cpl_ready,
  input  logic                 cpl_ok,
  input  logic [OFS_W-1:0]     cpl_dw_ofs,
  input  logic                 reg_wr_en,
  input  logic [SEL_W-1:0]     reg_sel,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [NUM_PAGES-1:0] status_o,
  output logic [NUM_PAGES-1:0] mask_o,
  output logic                 irq_o
);
  logic [NUM_PAGES-1:0] set_vec;
  logic [NUM_PAGES-1:0] clr_vec;
  logic [NUM_REGS-1:0]  mask_we;

  assign cpl_ready = 1'b1;

  pbi_page_decode #(.PAGE_LOG2(PAGE_LOG2), .NUM_PAGES(NUM_PAGES)) u_decode (
    .clk(clk), .rst_n(rst_n), .cpl_valid(cpl_valid), .cpl_ok(cpl_ok),
    .cpl_dw_ofs(cpl_dw_ofs), .set_vec(set_vec));

  pbi_reg_write #(.NUM_PAGES(NUM_PAGES), .REG_W(REG_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .sel(reg_sel),
    .wdata(reg_wdata), .clr_vec(clr_vec), .mask_we(mask_we));

  pbi_status_bank #(.NUM_PAGES(NUM_PAGES)) u_status (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .status(status_o));

  pbi_mask_bank #(.NUM_PAGES(NUM_PAGES), .REG_W(REG_W)) u_mask (
    .clk(clk), .rst_n(rst_n), .mask_we(mask_we), .wdata(reg_wdata),
    .mask(mask_o));

  assign irq_o = |(status_o & ~mask_o);

  // Errored or upper-half completions, with no write, leave status alone.
  assert_reject_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpl_ok && !reg_wr_en) |=> (status_o == $past(status_o)));
  assert_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_dw_ofs[OFS_W-1] && !reg_wr_en) |=> (status_o == $past(status_o)));
  assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpl_valid && !reg_wr_en) |=> (status_o == $past(status_o)));
endmodule

// File: tb/sim_page_irq_status.sv
module sim_page_irq_status;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpl_valid;
  logic        cpl_ready;
  logic        cpl_ok;
  logic [16:0] cpl_dw_ofs;
  logic        reg_wr_en;
  logic [1:0]  reg_sel;
  logic [31:0] reg_wdata;
  logic [63:0] status_o;
  logic [63:0] mask_o;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  logic [63:0] exp_stat;
  logic [63:0] exp_mask;

  always #2 clk = ~clk;

  page_irq_status u0 (
    .clk(clk), .rst_n(rst_n), .cpl_valid(cpl_valid), .cpl_ready(cpl_ready),
    .cpl_ok(cpl_ok), .cpl_dw_ofs(cpl_dw_ofs), .reg_wr_en(reg_wr_en),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .status_o(status_o),
    .mask_o(mask_o), .irq_o(irq_o));

  function automatic logic [16:0] mk(bit upper, int page, int dw);
    logic [5:0] pg = page[5:0];
    logic [9:0] d  = dw[9:0];
    return {upper, pg, d};
  endfunction

  // Next status from the requirements (R2-R8, R11).
  function automatic logic [63:0] next_stat(logic [63:0] s, logic v, logic ok,
      logic [16:0] ofs, logic we, logic [1:0] sel, logic [31:0] wd);
    logic [63:0] setv = '0;
    logic [63:0] clrv = '0;
    if (v && ok && !ofs[16] && (&ofs[9:0])) setv[ofs[15:10]] = 1'b1;
    if (we && sel == 2'd0) clrv[31:0]  = wd;
    if (we && sel == 2'd1) clrv[63:32] = wd;
    return (s & ~clrv) | setv;
  endfunction

  function automatic logic [63:0] next_mask(logic [63:0] m, logic we,
      logic [1:0] sel, logic [31:0] wd);
    logic [63:0] r = m;
    if (we && sel == 2'd2) r[31:0]  = wd;
    if (we && sel == 2'd3) r[63:32] = wd;
    return r;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk(req, status_o, exp_stat);
    chk({req, " mask"}, mask_o, exp_mask);
    chk({req, " irq R10"}, {63'd0, irq_o}, {63'd0, |(exp_stat & ~exp_mask)});
    chk({req, " ready R11"}, {63'd0, cpl_ready}, 64'd1);
  endtask

  // Drive one cycle at the falling edge, check at the next falling edge.
  task automatic cyc(string req, logic v, logic ok, logic [16:0] ofs,
      logic we, logic [1:0] sel, logic [31:0] wd);
    cpl_valid = v; cpl_ok = ok; cpl_dw_ofs = ofs;
    reg_wr_en = we; reg_sel = sel; reg_wdata = wd;
    exp_stat = next_stat(exp_stat, v, ok, ofs, we, sel, wd);
    exp_mask = next_mask(exp_mask, we, sel, wd);
    @(posedge clk);
    @(negedge clk);
    check_all(req);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5EED_0042);
    rst_n = 1'b0; cpl_valid = 0; cpl_ok = 0; cpl_dw_ofs = '0;
    reg_wr_en = 0; reg_sel = '0; reg_wdata = '0;
    exp_stat = '0; exp_mask = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all("R1 reset");
    rst_n = 1'b1;

    cyc("R2 page0 hit", 1, 1, mk(0, 0, 1023), 0, 0, 0);
    cyc("R6 page31", 1, 1, mk(0, 31, 1023), 0, 0, 0);
    cyc("R6 page32", 1, 1, mk(0, 32, 1023), 0, 0, 0);
    cyc("R6 page63", 1, 1, mk(0, 63, 1023), 0, 0, 0);
    cyc("R3 not last dw", 1, 1, mk(0, 5, 1022), 0, 0, 0);
    cyc("R3 first dw", 1, 1, mk(0, 6, 0), 0, 0, 0);
    cyc("R4 upper half", 1, 1, mk(1, 7, 1023), 0, 0, 0);
    cyc("R5 error cpl", 1, 0, mk(0, 8, 1023), 0, 0, 0);
    cyc("R11 valid low", 0, 1, mk(0, 9, 1023), 0, 0, 0);
    cyc("R7 zero write", 0, 0, '0, 1, 2'd0, 32'h0);
    cyc("R7 clear page63", 0, 0, '0, 1, 2'd1, 32'h8000_0000);
    cyc("R8 set beats clear", 1, 1, mk(0, 40, 1023), 1, 2'd1, 32'h0000_0100);
    cyc("R7 clear page40", 0, 0, '0, 1, 2'd1, 32'h0000_0100);
    cyc("R9 unmask page0", 0, 0, '0, 1, 2'd2, 32'hFFFF_FFFE);
    cyc("R10 irq follows clear", 0, 0, '0, 1, 2'd0, 32'h0000_0001);
    cyc("R9 high mask", 0, 0, '0, 1, 2'd3, 32'h0000_0000);
    cyc("R10 irq high word", 1, 1, mk(0, 50, 1023), 0, 0, 0);

    for (int i = 0; i < 800; i++) begin
      logic v, ok, up, we, last;
      int pg, dw;
      logic [1:0] sel;
      logic [31:0] wd;
      v    = ($urandom % 4) != 0;
      ok   = ($urandom % 5) != 0;
      up   = ($urandom % 5) == 0;
      last = ($urandom % 2) == 0;
      pg   = $urandom % 64;
      dw   = last ? 1023 : ($urandom % 1023);
      we   = ($urandom % 3) == 0;
      sel  = 2'($urandom % 4);
      wd   = $urandom;
      cyc("R2 R7 R10 random", v, ok, mk(up, pg, dw), we, sel, wd);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule